// File: doc/BRIEF.md
# SPI Master Word Exchanger

This block is a serial peripheral master that trades one word with an attached slave per transfer. Clock phase is fixed at 0. Before a transfer, software sets the clock idle level, the bit order, the word width (8 or 16 bits) and a divider exponent. It then presents a transmit word together with a one-cycle start strobe. The block pulls its select line low and waits one half clock period. It then toggles the serial clock once per half period, driving the outgoing bits and sampling the incoming line. After the last clock edge it holds select low for another half period, and then keeps select high for a further half period before it accepts the next word.

The received bits collect in a private shift register. They move to the visible receive register only at the final clock edge, so the previous word stays readable while a new one comes in. A completion flag rises at the same moment. The flag falls when software reads the status while the flag is set and afterwards reads the data.

Top module: `spi_master`

## Requirements
- R1: After reset, select is high, busy and the flag are 0, MOSI is 0, the receive word is 0, and the serial clock equals the polarity input whenever the block is idle.
- R2: The clock edge numbered k (k = 1 to 2n) occurs k·H system cycles after the cycle in which start was accepted. Select goes low in that accepting cycle, which gives a lead of H cycles before edge 1.
- R3: A transfer has exactly 2n clock edges, with n = 16 when the width input is 1 and n = 8 when it is 0.
- R4: When the polarity input is 0 the clock idles low, and when it is 1 it idles high. Edge 1 always moves the clock away from its idle level.
- R5: When the order input is 0, bit n-1 of the word goes first and bit 0 goes last. When it is 1, bit 0 goes first. The same order applies to sent and received bits, so both words are exchanged intact.
- R6: The first bit is on MOSI during the lead time. MOSI changes only at even edges, and MISO is sampled at odd edges. MOSI is 0 whenever select is high.
- R7: The receive word keeps its old value throughout a transfer and takes the new word (upper 8 bits zero in 8-bit mode) at edge 2n.
- R8: The completion flag is set in the cycle of edge 2n.
- R9: Select returns high H cycles after edge 2n and stays high for at least H more cycles while busy remains 1. Busy falls (2n+2)·H cycles after the accepting cycle.
- R10: The flag clears only on a data read that follows a status read made while the flag was set. A data read on its own does not clear it. A new completion takes priority over a clear in the same cycle.
- R11: A start strobe while busy is 1 is ignored, and the transfer in progress exchanges its original word.
- R12: The half period is H = 2^div_sel system cycles. The divider, width, order and polarity are captured when start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to send tx_word |
| tx_word | input | WORD_W | Word to transmit |
| wide | input | 1 | 1: 16-bit word, 0: 8-bit word |
| cpol | input | 1 | Serial clock idle level |
| lsb_first | input | 1 | 1: least significant bit first |
| div_sel | input | DIV_W | Half period = 2^div_sel cycles |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe |
| miso | input | 1 | Serial data from slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Transfer or gap in progress |
| done | output | 1 | Completion flag |
| rx_word | output | WORD_W | Last received word |

## Verification
A corrupted timer or edge counter moves a serial clock edge or the select release, and the cycle-accurate comparison catches this in that cycle. A wrong bit-position selection puts a wrong MOSI bit on the line within one half period. On the receive side it shows only at edge 2n, through the receive word and through the word the slave collected. Flag-sequencing faults appear in the cycle after the read strobes.

// File: rtl/spi_master.sv
module spi_master #(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              wide,
  input  logic              cpol,
  input  logic              lsb_first,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  localparam int TW = 1 << DIV_W;
  localparam int EW = $clog2(2*WORD_W + 1);
  localparam int PW = $clog2(WORD_W);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL, S_GAP} st_t;

  st_t               st;
  logic [TW-1:0]     tmr, hm1_q;
  logic [EW-1:0]     ecnt, last;
  logic              sck_q, ss_q, wide_q, lsb_q, armed;
  logic [WORD_W-1:0] tx_q, rx_sh, rx_q;
  logic [PW-1:0]     pos;
  logic [EW-1:0]     idx;

  assign last = wide_q ? EW'(2*WORD_W) : EW'(WORD_W);
  assign idx  = {1'b0, ecnt[EW-1:1]};

  always_comb begin
    if (lsb_q) pos = PW'(idx);
    else       pos = wide_q ? PW'(EW'(WORD_W-1) - idx) : PW'(EW'(WORD_W/2-1) - idx);
  end

  assign sck     = (st == S_IDLE) ? cpol : sck_q;
  assign mosi    = (st == S_LEAD || st == S_SHIFT) ? tx_q[pos] : 1'b0;
  assign ss_n    = ss_q;
  assign busy    = (st != S_IDLE);
  assign rx_word = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; hm1_q <= '0; ecnt <= '0;
      sck_q <= 1'b0; ss_q <= 1'b1; wide_q <= 1'b0; lsb_q <= 1'b0;
      tx_q <= '0; rx_sh <= '0; rx_q <= '0; done <= 1'b0; armed <= 1'b0;
    end else begin
      if (stat_rd && done) armed <= 1'b1;
      if (data_rd && armed) begin
        done  <= 1'b0;
        armed <= 1'b0;
      end
      if (st == S_IDLE) begin
        if (start) begin
          st     <= S_LEAD;
          hm1_q  <= (TW'(1) << div_sel) - TW'(1);
          tmr    <= (TW'(1) << div_sel) - TW'(1);
          wide_q <= wide;
          lsb_q  <= lsb_first;
          sck_q  <= cpol;
          tx_q   <= tx_word;
          rx_sh  <= '0;
          ecnt   <= '0;
          ss_q   <= 1'b0;
        end
      end else if (tmr != '0) begin
        tmr <= tmr - TW'(1);
      end else begin
        tmr <= hm1_q;
        case (st)
          S_LEAD, S_SHIFT: begin
            sck_q <= ~sck_q;
            ecnt  <= ecnt + EW'(1);
            if (!ecnt[0]) rx_sh[pos] <= miso;
            if (ecnt + EW'(1) == last) begin
              st    <= S_TRAIL;
              rx_q  <= rx_sh;
              done  <= 1'b1;
              armed <= 1'b0;
            end else begin
              st <= S_SHIFT;
            end
          end
          S_TRAIL: begin
            ss_q <= 1'b1;
            st   <= S_GAP;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module spi_master_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ss_n,
  input logic              sck,
  input logic              cpol,
  input logic              mosi,
  input logic              done,
  input logic [WORD_W-1:0] rx_word
);
  logic       sck_d;
  logic [7:0] edges;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      edges <= '0;
    end else begin
      sck_d <= sck;
      if (!busy) edges <= '0;
      else if (sck != sck_d) edges <= edges + 8'd1;
    end
  end

  assert_idle_ss_R1: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> ss_n);
  assert_idle_sck_R4: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sck == cpol);
  assert_mosi_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n) ss_n |-> !mosi);
  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n) (busy && !$stable(rx_word)) |-> done);
  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n) $rose(ss_n) |-> busy);
  assert_edge_count_R3: assert property (@(posedge clk) disable iff (!rst_n) edges <= 8'(2*WORD_W));
endmodule

bind spi_master spi_master_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ss_n(ss_n), .sck(sck),
  .cpol(cpol), .mosi(mosi), .done(done), .rx_word(rx_word)
);

// File: tb/spi_master_bench.sv
module spi_master_bench;
  logic clk = 0, rst_n = 0;
  logic start = 0, wide = 0, cpol = 0, lsb_first = 0, stat_rd = 0, data_rd = 0;
  logic [15:0] tx_word = 0;
  logic [2:0]  div_sel = 0;
  logic sck, mosi, ss_n, busy, done, miso;
  logic [15:0] rx_word;

  int total = 0, bad = 0, cyc = 0;

  spi_master u_spi_master (.*);

  always #2 clk = ~clk;

  // behavioural slave
  logic [15:0] s_tx = 0, s_rx = 0;
  int s_cnt = 0, s_n = 8;
  logic s_lsb = 0;
  function automatic int bpos(int j, int n, logic lb);
    return lb ? j : n - 1 - j;
  endfunction
  always @(negedge ss_n) begin s_cnt = 0; s_rx = 0; s_n = wide ? 16 : 8; s_lsb = lsb_first; end
  always @(sck) if (!ss_n && busy) begin
    s_cnt = s_cnt + 1;
    if (s_cnt % 2 == 1) s_rx[bpos((s_cnt-1)/2, s_n, s_lsb)] = mosi;
  end
  assign miso = (!ss_n && s_cnt/2 < s_n) ? s_tx[bpos(s_cnt/2, s_n, s_lsb)] : 1'b0;

  // reference model
  bit m_act = 0, m_flag = 0, m_arm = 0, m_cpol = 0, m_lsb = 0;
  int d = 0, H = 1, n = 8;
  logic [15:0] m_tx = 0, m_sw = 0, m_rx = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_flag = 0; m_arm = 0; m_rx = 0;
    end else begin
      if (stat_rd && m_flag) m_arm = 1;
      if (data_rd && m_arm) begin m_flag = 0; m_arm = 0; end
      if (m_act) begin
        d = d + 1;
        if (d == 2*n*H) begin
          m_flag = 1; m_arm = 0;
          m_rx = (n == 16) ? m_sw : (m_sw & 16'h00FF);
        end
        if (d == (2*n+2)*H) m_act = 0;
      end else if (start) begin
        m_act = 1; d = 0; H = 1 << div_sel; n = wide ? 16 : 8;
        m_cpol = cpol; m_lsb = lsb_first; m_tx = tx_word; m_sw = s_tx;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int k, e_sck, e_ss, e_mosi;
    if (!m_act) begin
      e_sck = cpol; e_ss = 1; e_mosi = 0;
    end else begin
      k = d / H; if (k > 2*n) k = 2*n;
      e_sck  = m_cpol ^ (k % 2);
      e_ss   = (d >= (2*n+1)*H) ? 1 : 0;
      e_mosi = (k < 2*n) ? m_tx[bpos(k/2, n, m_lsb)] : 0;
    end
    chk("R2/R3/R4 sck", sck, e_sck);
    chk("R9 ss_n", ss_n, e_ss);
    chk("R5/R6 mosi", mosi, e_mosi);
    chk("R9 busy", busy, m_act);
    chk("R8/R10 done", done, m_flag);
    chk("R7 rx_word", rx_word, m_rx);
  end

  task automatic pulse_rd(bit st, bit dt);
    @(posedge clk); #1 stat_rd = st; data_rd = dt;
    @(posedge clk); #1 stat_rd = 0; data_rd = 0;
  endtask

  task automatic xfer(bit cp, bit lb, bit wd, logic [2:0] dv, logic [15:0] mw, logic [15:0] sw);
    logic [15:0] msk;
    msk = wd ? 16'hFFFF : 16'h00FF;
    @(posedge clk); #1 cpol = cp; lsb_first = lb; wide = wd; div_sel = dv;
    s_tx = sw; tx_word = mw; start = 1;
    @(posedge clk); #1 start = 0;
    repeat (5) @(posedge clk);
    #1 tx_word = ~mw; start = 1;   // R11: ignored while busy
    @(posedge clk); #1 start = 0; tx_word = mw;
    while (m_act) @(posedge clk);
    #1;
    chk("R5/R11 slave got master word", s_rx, mw & msk);
    chk("R5 master got slave word", rx_word, sw & msk);
    pulse_rd(0, 1);
    chk("R10 data read alone keeps flag", done, 1);
    pulse_rd(1, 0);
    pulse_rd(0, 1);
    chk("R10 flag cleared", done, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ss_n reset", ss_n, 1);
    chk("R1 busy reset", busy, 0);
    chk("R1 done reset", done, 0);
    chk("R1 rx reset", rx_word, 0);
    chk("R1 sck idle", sck, cpol);
    rst_n = 1;
    for (int c = 0; c < 2; c++)
      for (int l = 0; l < 2; l++)
        for (int w = 0; w < 2; w++)
          for (int v = 0; v < 2; v++)
            xfer(c[0], l[0], w[0], v[2:0], 16'hA5C3 ^ 16'(c*16'h1111 + l*16'h0302 + w*16'h4000 + v),
                 16'h3C96 ^ 16'(c*16'h0808 + l*16'h2010 + w*16'h0101 + v*16'h8000));
    xfer(1, 0, 1, 3'd2, 16'h8001, 16'h7FFE);   // R12 wider divider
    cpol = 1; @(posedge clk); #1;
    chk("R4 idle sck follows polarity", sck, 1);
    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule